// File: doc/BRIEF.md
# Half-Warp Load Coalescer

This block turns one load request from sixteen threads into the shortest list of aligned memory transactions that covers every active thread. Each thread brings its own byte address. The request also carries an active mask and one word-size code that all threads share. The block keeps a working copy of the mask. Each round starts from the lowest-numbered thread that is still active, and takes the naturally aligned segment that holds that thread's word. Every other active thread whose word falls in the same segment joins the round. The transaction is then halved while the touched bytes occupy only one half of it, first from 128 to 64 bytes and then from 64 to 32 bytes. The block issues the transaction with the mask of the threads it serves and clears those threads. Rounds repeat until no active thread is left. A full 32-thread warp is handled as two independent requests, one per half.

A request is taken with a valid/ready pair. Transactions leave on a valid/ready stream that carries a base address, a length code and a thread mask. A one-cycle completion pulse follows the last transaction. No data moves through the block.

The control path is a four-state machine:
- IDLE waits for a request. It goes to SCAN when the mask is non-empty and to FINISH when the mask is empty.
- SCAN forms the next transaction into the output registers and always goes on to ISSUE.
- ISSUE presents that transaction. When the transaction is taken, it returns to SCAN if threads remain, or goes to FINISH if none do.
- FINISH raises the completion pulse for one cycle and returns to IDLE.

Top module: `hw_coalescer`

## Requirements
- R1: After reset, `req_ready` is 1, `txn_valid` is 0 and `done` is 0.
- R2: The word-size code selects the word size and the segment size:
  - code 0: 1-byte words, 32-byte segments.
  - code 1: 2-byte words, 64-byte segments.
  - codes 2, 3 and 4: 4-, 8- and 16-byte words, 128-byte segments.
  - codes 5 to 7: treated as code 4.

  Address bits below the word size are ignored.
- R3: Every transaction contains the lowest-numbered thread that is still active. Its base lies in the segment that holds that thread's word.
- R4: A transaction serves every still-active thread whose word lies in the same segment as the leading thread. It serves no thread whose word lies outside that segment.
- R5: A 128-byte transaction whose touched bytes lie wholly in its lower half, or wholly in its upper half, becomes a 64-byte transaction covering that half.
- R6: A 64-byte transaction whose touched bytes lie in one half becomes a 32-byte transaction. This applies whether the 64 bytes were the original segment size or the result of R5.
- R7: `txn_len` encodes the length as 0 for 32 bytes, 1 for 64 bytes and 2 for 128 bytes. `txn_base` is always a multiple of that length.
- R8: Served threads retire when their transaction is taken, and rounds repeat until none remain.
  - Example: sixteen 4-byte words at a 128-byte stride give sixteen 32-byte transactions.
  - Example: sixteen consecutive 4-byte words starting 80 bytes into a segment give one 64-byte and one 32-byte transaction.

  `done` is high for exactly one cycle, after the last transaction is taken, and then `req_ready` returns.
- R9: While `txn_valid` is high and `txn_ready` is low, the transaction stays on the outputs unchanged.
- R10: A request with an empty mask produces no transaction. `done` rises in the cycle after acceptance.
- R11: `req_ready` stays low from acceptance until the completion pulse. Requests offered in that time are ignored.
- R12: Threads outside the request mask never appear in any transaction, wherever their addresses point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | NT*AW | Thread addresses; thread i in bits [i*AW +: AW] |
| req_mask | input | NT | Active threads |
| req_size | input | 3 | Word-size code (see R2) |
| txn_valid | output | 1 | Transaction presented |
| txn_ready | input | 1 | Transaction taken |
| txn_base | output | AW | Transaction base byte address |
| txn_len | output | 2 | Length code (see R7) |
| txn_mask | output | NT | Threads served by this transaction |
| done | output | 1 | One-cycle completion pulse |

## Verification
A corrupted remaining-thread mask shows on the very next transaction. A thread is then served twice, dropped, or led out of order, and the whole list of transactions for the request drifts from the computed one. A wrong segment or halving decision shows in the same cycle as a misaligned base, a wrong length code or a split or merged thread mask. A stuck state shows as a missing or doubled completion pulse within a few cycles of the final handshake. Backpressure is applied at random, so that a transaction that changes while stalled is caught one cycle after the stall begins.

// File: rtl/coal_pkg.sv
package coal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_ISSUE  = 2'd2,
        ST_FINISH = 2'd3
    } coal_state_e;

    localparam int SZ_W    = 3;
    localparam int LEN_W   = 2;
    localparam int OFF_W   = 7;   // byte offset inside the widest segment
    localparam int MIN_LG  = 5;   // log2 of the narrowest transaction

    // log2 of the word size; codes above 4 behave as 16-byte words
    function automatic logic [SZ_W-1:0] word_lg(input logic [SZ_W-1:0] code);
        return (code > 3'd4) ? 3'd4 : code;
    endfunction

    // log2 of the segment size for a given word log2
    function automatic logic [SZ_W-1:0] seg_lg(input logic [SZ_W-1:0] wlg);
        logic [SZ_W-1:0] r;
        unique case (wlg)
            3'd0:    r = 3'd5;
            3'd1:    r = 3'd6;
            default: r = 3'd7;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/coal_lead_pick.sv
module coal_lead_pick #(
    parameter int NT = 16,
    parameter int IW = $clog2(NT)
) (
    input  logic [NT-1:0] mask,
    output logic [IW-1:0] idx
);
    // lowest set bit wins: scan from the top so the last write is the lowest
    always_comb begin
        idx = '0;
        for (int i = NT - 1; i >= 0; i--) begin
            if (mask[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/coal_seg_match.sv
module coal_seg_match
    import coal_pkg::*;
#(
    parameter int NT = 16,
    parameter int AW = 32,
    parameter int IW = $clog2(NT)
) (
    input  logic [NT*AW-1:0]  addrs,
    input  logic [NT-1:0]     mask,
    input  logic [IW-1:0]     lead,
    input  logic [SZ_W-1:0]   wlg,
    input  logic [SZ_W-1:0]   slg,
    output logic [NT-1:0]     hit,
    output logic [AW-1:0]     seg_base,
    output logic [OFF_W-1:0]  off_lo,
    output logic [OFF_W-1:0]  off_hi
);
    logic [AW-1:0]    lead_a;
    logic [OFF_W-1:0] wmask;
    logic [OFF_W-1:0] smask;
    logic [OFF_W-1:0] lo_v [NT];
    logic [OFF_W-1:0] hi_v [NT];

    assign lead_a   = addrs[int'(lead)*AW +: AW];
    assign wmask    = OFF_W'((8'd1 << wlg) - 8'd1);
    assign smask    = OFF_W'((8'd1 << slg) - 8'd1);
    assign seg_base = lead_a & ~((AW'(1) << slg) - AW'(1));

    for (genvar g = 0; g < NT; g++) begin : g_thr
        logic [AW-1:0] a;
        assign a       = addrs[g*AW +: AW];
        assign hit[g]  = mask[g] && ((a >> slg) == (lead_a >> slg));
        assign lo_v[g] = a[OFF_W-1:0] & ~wmask & smask;
        assign hi_v[g] = lo_v[g] + wmask;
    end

    // span of bytes touched by the gathered threads, relative to the segment
    always_comb begin
        off_lo = '1;
        off_hi = '0;
        for (int i = 0; i < NT; i++) begin
            if (hit[i]) begin
                if (lo_v[i] < off_lo) off_lo = lo_v[i];
                if (hi_v[i] > off_hi) off_hi = hi_v[i];
            end
        end
    end
endmodule

// File: rtl/coal_shrink.sv
module coal_shrink
    import coal_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]    seg_base,
    input  logic [SZ_W-1:0]  slg,
    input  logic [OFF_W-1:0] off_lo,
    input  logic [OFF_W-1:0] off_hi,
    output logic [AW-1:0]    base,
    output logic [LEN_W-1:0] len
);
    logic [SZ_W-1:0]  lg;
    logic [OFF_W-1:0] lo;
    logic [OFF_W-1:0] hi;

    always_comb begin
        base = seg_base;
        lg   = slg;
        lo   = off_lo;
        hi   = off_hi;
        // first halving: 128 -> 64
        if (lg == 3'd7) begin
            if (hi < 7'd64) begin
                lg = 3'd6;
            end else if (lo >= 7'd64) begin
                lg   = 3'd6;
                base = base + AW'(64);
                lo   = lo - 7'd64;
                hi   = hi - 7'd64;
            end
        end
        // second halving: 64 -> 32, also after the first
        if (lg == 3'd6) begin
            if (hi < 7'd32) begin
                lg = 3'd5;
            end else if (lo >= 7'd32) begin
                lg   = 3'd5;
                base = base + AW'(32);
            end
        end
        len = LEN_W'(lg - SZ_W'(MIN_LG));
    end
endmodule

// File: rtl/hw_coalescer.sv
module hw_coalescer
    import coal_pkg::*;
#(
    parameter int NT = 16,
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [NT*AW-1:0] req_addr,
    input  logic [NT-1:0]    req_mask,
    input  logic [2:0]       req_size,
    output logic             txn_valid,
    input  logic             txn_ready,
    output logic [AW-1:0]    txn_base,
    output logic [1:0]       txn_len,
    output logic [NT-1:0]    txn_mask,
    output logic             done
);
    localparam int IW = $clog2(NT);

    coal_state_e st_q, st_d;

    logic [NT*AW-1:0] addr_q;
    logic [NT-1:0]    rem_q;
    logic [SZ_W-1:0]  wlg_q;
    logic [AW-1:0]    base_q;
    logic [LEN_W-1:0] len_q;
    logic [NT-1:0]    tmask_q;

    logic [IW-1:0]    lead_idx;
    logic [SZ_W-1:0]  slg;
    logic [NT-1:0]    hit;
    logic [AW-1:0]    sbase;
    logic [OFF_W-1:0] off_lo, off_hi;
    logic [AW-1:0]    nbase;
    logic [LEN_W-1:0] nlen;
    logic             accept, fire;
    logic [NT-1:0]    rem_after;

    assign slg       = seg_lg(wlg_q);
    assign accept    = req_valid && (st_q == ST_IDLE);
    assign fire      = txn_ready && (st_q == ST_ISSUE);
    assign rem_after = rem_q & ~tmask_q;

    coal_lead_pick #(.NT(NT), .IW(IW)) u_pick (
        .mask (rem_q),
        .idx  (lead_idx)
    );

    coal_seg_match #(.NT(NT), .AW(AW), .IW(IW)) u_match (
        .addrs    (addr_q),
        .mask     (rem_q),
        .lead     (lead_idx),
        .wlg      (wlg_q),
        .slg      (slg),
        .hit      (hit),
        .seg_base (sbase),
        .off_lo   (off_lo),
        .off_hi   (off_hi)
    );

    coal_shrink #(.AW(AW)) u_shrink (
        .seg_base (sbase),
        .slg      (slg),
        .off_lo   (off_lo),
        .off_hi   (off_hi),
        .base     (nbase),
        .len      (nlen)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (req_valid) st_d = (|req_mask) ? ST_SCAN : ST_FINISH;
            ST_SCAN:   st_d = ST_ISSUE;
            ST_ISSUE:  if (txn_ready) st_d = (|rem_after) ? ST_SCAN : ST_FINISH;
            ST_FINISH: st_d = ST_IDLE;
        endcase
    end

    // request and transaction registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            rem_q   <= '0;
            wlg_q   <= '0;
            base_q  <= '0;
            len_q   <= '0;
            tmask_q <= '0;
        end else begin
            if (accept) begin
                addr_q <= req_addr;
                rem_q  <= req_mask;
                wlg_q  <= word_lg(req_size);
            end
            if (st_q == ST_SCAN) begin
                base_q  <= nbase;
                len_q   <= nlen;
                tmask_q <= hit;
            end
            if (fire) rem_q <= rem_after;
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        txn_valid = 1'b0;
        done      = 1'b0;
        unique case (st_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_SCAN:   ;
            ST_ISSUE:  txn_valid = 1'b1;
            ST_FINISH: done      = 1'b1;
        endcase
    end
    assign txn_base = base_q;
    assign txn_len  = len_q;
    assign txn_mask = tmask_q;

endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
    parameter int NT = 16,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          txn_valid,
    input logic          txn_ready,
    input logic [AW-1:0] txn_base,
    input logic [1:0]    txn_len,
    input logic [NT-1:0] txn_mask,
    input logic          done,
    input logic [NT-1:0] rem_mask
);
    // R3: the lowest still-active thread is part of the transaction
    p_lead_in_txn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_mask & rem_mask & (~rem_mask + NT'(1))) != '0);

    // R12: only still-active threads are served, and at least one
    p_only_active_r12: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_mask & ~rem_mask) == '0) && (txn_mask != '0));

    // R7: legal length code and base aligned to the length
    p_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_len != 2'd3) &&
                      ((txn_base & ((AW'(32) << txn_len) - AW'(1))) == '0));

    // R9: stalled transaction is held
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_base) &&
                                    $stable(txn_len) && $stable(txn_mask));

    // R8: served threads retire on handshake
    p_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && txn_ready |=> (rem_mask & $past(txn_mask)) == '0);

    // R8: completion is a single pulse followed by readiness
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

    // R11: no new request while a transaction is pending
    p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> !req_ready);
endmodule

bind hw_coalescer coal_checker #(.NT(NT), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .txn_valid (txn_valid),
    .txn_ready (txn_ready),
    .txn_base  (txn_base),
    .txn_len   (txn_len),
    .txn_mask  (txn_mask),
    .done      (done),
    .rem_mask  (rem_q)
);

// File: tb/hw_coalescer_tb_top.sv
module hw_coalescer_tb_top;
    localparam int NT = 16;
    localparam int AW = 32;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid;
    logic             req_ready;
    logic [NT*AW-1:0] req_addr;
    logic [NT-1:0]    req_mask;
    logic [2:0]       req_size;
    logic             txn_valid;
    logic             txn_ready;
    logic [AW-1:0]    txn_base;
    logic [1:0]       txn_len;
    logic [NT-1:0]    txn_mask;
    logic             done;

    int checks = 0;
    int fails  = 0;

    int unsigned ta [NT];
    int unsigned e_base [NT];
    int unsigned e_len  [NT];
    logic [NT-1:0] e_mask [NT];
    int e_n;

    always #10 clk = ~clk;

    hw_coalescer #(.NT(NT), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask), .req_size(req_size),
        .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_base(txn_base), .txn_len(txn_len), .txn_mask(txn_mask),
        .done(done)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // arithmetic reference: list of transactions for the current ta[]
    task automatic build_model(input logic [NT-1:0] m, input logic [2:0] sz);
        int unsigned wb, sb, L, b, half, st, en, la, lead;
        logic [NT-1:0] rem, mem;
        bit lo_u, hi_u, go;
        int szc;
        szc = (sz > 3'd4) ? 4 : int'(sz);
        wb  = 32'd1 << szc;
        sb  = (szc == 0) ? 32 : (szc == 1) ? 64 : 128;
        rem = m;
        e_n = 0;
        while (rem != '0) begin
            lead = 0;
            for (int i = NT - 1; i >= 0; i--) if (rem[i]) lead = i;
            la  = ta[lead] & ~(wb - 1);
            mem = '0;
            for (int i = 0; i < NT; i++)
                if (rem[i] && (((ta[i] & ~(wb - 1)) / sb) == (la / sb))) mem[i] = 1'b1;
            b  = la - (la % sb);
            L  = sb;
            go = 1;
            while (go && L > 32) begin
                half = L / 2; lo_u = 0; hi_u = 0;
                for (int i = 0; i < NT; i++) begin
                    if (mem[i]) begin
                        st = (ta[i] & ~(wb - 1)) - b;
                        en = st + wb - 1;
                        if (st < half) lo_u = 1;
                        if (en >= half) hi_u = 1;
                    end
                end
                if (lo_u && !hi_u) L = half;
                else if (hi_u && !lo_u) begin b = b + half; L = half; end
                else go = 0;
            end
            e_base[e_n] = b;
            e_len[e_n]  = (L == 32) ? 0 : (L == 64) ? 1 : 2;
            e_mask[e_n] = mem;
            e_n++;
            rem = rem & ~mem;
        end
    endtask

    // drive one request, collect and compare all transactions
    task automatic run_req(input logic [NT-1:0] m, input logic [2:0] sz, input string tag);
        int got, cyc;
        bit held, fin;
        logic [AW-1:0] h_base; logic [1:0] h_len; logic [NT-1:0] h_mask;
        build_model(m, sz);
        @(negedge clk);
        for (int i = 0; i < NT; i++) req_addr[i*AW +: AW] = ta[i];
        req_mask  = m;
        req_size  = sz;
        req_valid = 1'b1;
        txn_ready = 1'b0;
        chk(req_ready === 1'b1, "R11", "ready when idle", req_ready, 1);
        @(negedge clk);
        // keep offering a junk request while busy: it must be ignored (R11)
        req_mask = ~m;
        req_addr = ~req_addr;
        got = 0; cyc = 0; held = 0; fin = 0;
        while (!fin && cyc < 3000) begin
            if (held) begin
                chk(txn_valid && txn_base == h_base && txn_len == h_len && txn_mask == h_mask,
                    "R9", "held txn", {txn_base, txn_len, txn_mask}, {h_base, h_len, h_mask});
                held = 0;
            end
            if (done) begin
                chk(got == e_n, "R8", "txn count", got, e_n);
                if (e_n == 0) chk(cyc == 0, "R10", "empty mask done cycle", cyc, 0);
                req_valid = 1'b0;
                txn_ready = 1'b0;
                fin = 1;
            end else begin
                if (req_ready) chk(0, "R11", "ready while busy", 1, 0);
                if (txn_valid) begin
                    txn_ready = ($urandom % 3) != 0;
                    if (txn_ready) begin
                        if (got < e_n) begin
                            chk(txn_mask == e_mask[got], "R4", "txn mask", txn_mask, e_mask[got]);
                            chk(txn_base == e_base[got], "R3", "txn base", txn_base, e_base[got]);
                            chk(txn_len == e_len[got], tag, "txn len", txn_len, e_len[got]);
                        end else begin
                            chk(0, "R12", "extra txn", got + 1, e_n);
                        end
                        got++;
                    end else begin
                        held = 1; h_base = txn_base; h_len = txn_len; h_mask = txn_mask;
                    end
                end else begin
                    txn_ready = ($urandom % 2) != 0;
                end
            end
            @(negedge clk);
            cyc++;
        end
        chk(fin, "R8", "done seen", fin, 1);
        chk(!done && req_ready, "R8", "single done pulse", {done, req_ready}, 2'b01);
    endtask

    task automatic fill_seq(input int unsigned start, input int unsigned step);
        for (int i = 0; i < NT; i++) ta[i] = start + i * step;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_mask = '0;
        req_size = '0; txn_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1 && txn_valid === 1'b0 && done === 1'b0, "R1", "reset outputs",
            {req_ready, txn_valid, done}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && txn_valid === 1'b0 && done === 1'b0, "R1", "after release",
            {req_ready, txn_valid, done}, 3'b100);

        // R5: sequential aligned 4-byte words -> one 64-byte transaction
        fill_seq(32'h1000, 4);  run_req(16'hffff, 3'd2, "R5");
        chk(e_n == 1 && e_len[0] == 1, "R5", "model seq", e_len[0], 1);
        // R2: word sizes
        fill_seq(32'h2010, 1);  run_req(16'hffff, 3'd0, "R2");
        fill_seq(32'h3000, 2);  run_req(16'hffff, 3'd1, "R6");
        fill_seq(32'h3800, 8);  run_req(16'hffff, 3'd3, "R2");
        fill_seq(32'h4000, 16); run_req(16'hffff, 3'd4, "R2");
        fill_seq(32'h4400, 16); run_req(16'hffff, 3'd6, "R2");
        fill_seq(32'h4801, 4);  run_req(16'hffff, 3'd2, "R2");
        // R8: strided and misaligned
        fill_seq(32'h8000, 128); run_req(16'hffff, 3'd2, "R8");
        chk(e_n == 16, "R8", "stride count", e_n, 16);
        fill_seq(32'h9050, 4);   run_req(16'hffff, 3'd2, "R8");
        chk(e_n == 2 && e_len[0] == 1 && e_len[1] == 0, "R8", "misaligned split",
            {e_n, e_len[0], e_len[1]}, {32'd2, 32'd1, 32'd0});
        // R5 / R6: upper half only
        fill_seq(32'h5040, 4);   run_req(16'hffff, 3'd2, "R5");
        fill_seq(32'h5060, 4);   run_req(16'h00ff, 3'd2, "R6");
        // R4: reversed order within one segment
        for (int i = 0; i < NT; i++) ta[i] = 32'h6000 + (NT - 1 - i) * 4;
        run_req(16'hffff, 3'd2, "R4");
        // R10: empty mask
        run_req(16'h0000, 3'd2, "R10");
        // R12: inactive threads point far away
        fill_seq(32'h7000, 4);
        for (int i = 8; i < NT; i++) ta[i] = 32'h00F0_0000 + i * 256;
        run_req(16'h00ff, 3'd2, "R12");

        // sweep: every size code, random addresses in a small window, random masks
        for (int sz = 0; sz < 8; sz++) begin
            for (int it = 0; it < 30; it++) begin
                int unsigned win;
                logic [NT-1:0] m;
                win = (it % 3 == 0) ? 128 : (it % 3 == 1) ? 512 : 4096;
                for (int i = 0; i < NT; i++) ta[i] = 32'h0010_0000 + ($urandom % win);
                m = NT'($urandom);
                if (it % 5 == 0) m = '1;
                run_req(m, 3'(sz), (sz < 2) ? "R6" : "R5");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule